// File: doc/BRIEF.md
# PCI Write Command Selector for Outbound DMA

This block sits between an outbound (memory-to-PCI) DMA channel and the PCI bus engine that drives the pins. For each burst, it looks at the descriptor's requested transfer kind, the invalidate-enable bit from configuration space, the current bus address, the bytes still to send, the cache line size and the number of words waiting in the output FIFO. From these it picks one of three PCI write commands and a word limit for the burst. It then raises a start request and holds it until the bus engine takes it.

A request for memory write and invalidate is honoured only when promotion is legal. The invalidate-enable bit must be set, the line size must be a non-zero power of two, the address must sit on a line boundary, and at least one whole line must remain. When all of this holds, the burst waits until a full line is in the FIFO, and its limit is always a whole number of lines. In every other case the command falls back to plain memory write. This covers a burst that resumes partway through a line after a target disconnect. While promotion stays enabled but the address is off a boundary, the plain write stops at the next line boundary, so the following line can be promoted again.

The sequencer has four states. IDLE goes to EVAL when `req_valid` is high. EVAL returns to IDLE if the request is dropped or nothing remains to send. EVAL stays in EVAL while there is not enough data, and goes to ISSUE when the decision is ready; on that step it latches the command and limit. ISSUE goes to BUSY on `start_ack`. BUSY goes back to IDLE on `burst_done` or `target_disc`.

Top module: `pci_wcmd_sel`

## Requirements
- R1: After reset, `start_req` is 0, `cbe_cmd` is 4'b0000 and `burst_lim` is 0.
- R2: `xfer_type` 2'b00 (memory write) selects command 4'b0111 with limit min(FIFO words, ceil(remaining bytes / 4), 255).
- R3: `xfer_type` 2'b10 (I/O write) selects command 4'b0011 with the same limit rule as R2, whatever the other inputs.
- R4: `xfer_type` 2'b01 (invalidate requested) with `inv_en` = 0 selects 4'b0111, with the R2 limit and no line-boundary cap.
- R5: Invalidate requested, `inv_en` = 1, valid line size, address aligned to a line (word address multiple of `line_words`, byte bits [1:0] zero) and floor(remaining/4) >= `line_words`: command 4'b1111, limit = min(FIFO words, floor(remaining/4), 255) rounded down to a multiple of `line_words`.
- R6: Invalidate requested and enabled with a valid line size, but the address is unaligned or less than one line remains: command 4'b0111, limit = R2 limit further capped at the words left to the next line boundary.
- R7: A promoted burst does not start while the FIFO holds fewer than `line_words` words, and starts once it holds a full line.
- R8: A `line_words` of zero, or a value that is not a power of two, disables promotion: command 4'b0111 with the uncapped R2 limit.
- R9: While `start_req` is high and `start_ack` is low, `start_req`, `cbe_cmd` and `burst_lim` stay unchanged, even if the inputs change.
- R10: After a `target_disc` partway through a promoted line, the next burst is 4'b0111 ending at the line boundary, and the line after that is promoted again.
- R11: No start is requested when the FIFO is empty or zero bytes remain, and every issued `burst_lim` is non-zero and no larger than the FIFO level seen at decision time.
- R12: The reserved `xfer_type` 2'b11 is handled as memory write (4'b0111).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Channel has a burst to place |
| xfer_type | input | 2 | Requested kind: 00 mem write, 01 mem write+invalidate, 10 I/O write, 11 reserved |
| inv_en | input | 1 | Invalidate enable from configuration space |
| cur_addr | input | ADDR_W | PCI byte address of the next word |
| remain_bytes | input | CNT_W | Bytes still to transfer |
| line_words | input | CLS_W | Cache line size in 32-bit words |
| fifo_words | input | LVL_W | Words currently held in the output FIFO |
| start_ack | input | 1 | Bus engine accepted the start |
| burst_done | input | 1 | Burst finished normally |
| target_disc | input | 1 | Target disconnected the burst early |
| start_req | output | 1 | Request to start a burst |
| cbe_cmd | output | 4 | PCI command for the address phase |
| burst_lim | output | BURST_W | Maximum words in this burst |

## Verification
Assertions check on every cycle that a pending start keeps its command and limit until it is acknowledged. They also check that each issued burst has a legal non-zero limit within the FIFO level, that a promoted command never appears without the enable bit or a full line in the FIFO, that its limit is a whole number of lines, and that I/O requests always give the I/O command. The values of the limits, the demotions for unaligned addresses, short tails and bad line sizes, the waiting for data, and the recovery across a disconnect and the next line can only be shown by the bench's scenarios, which compare against hand-computed results.

// File: rtl/pci_wcmd_pkg.sv
package pci_wcmd_pkg;

    typedef enum logic [1:0] {
        XT_MEMWR    = 2'b00,
        XT_MEMWRINV = 2'b01,
        XT_IOWR     = 2'b10,
        XT_RSVD     = 2'b11
    } xfer_kind_t;

    localparam logic [3:0] CMD_MEMWR    = 4'b0111;
    localparam logic [3:0] CMD_MEMWRINV = 4'b1111;
    localparam logic [3:0] CMD_IOWR     = 4'b0011;
    localparam logic [3:0] CMD_NONE     = 4'b0000;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_EVAL,
        ST_ISSUE,
        ST_BUSY
    } sel_state_t;

    function automatic logic [31:0] min_u32(input logic [31:0] a, input logic [31:0] b);
        return (a < b) ? a : b;
    endfunction

endpackage

// File: rtl/pci_wcmd_linegeo.sv
module pci_wcmd_linegeo #(
    parameter int ADDR_W = 32,
    parameter int CLS_W  = 8
) (
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [CLS_W-1:0]  line_words,
    output logic              line_ok,
    output logic [31:0]       line_mask,
    output logic              aligned,
    output logic [31:0]       to_boundary
);

    logic [31:0] line32;
    logic [31:0] word32;
    logic [31:0] offs;

    always_comb begin
        line32      = 32'(line_words);
        word32      = 32'(cur_addr[ADDR_W-1:2]);
        // legal line: non-zero power of two
        line_ok     = (line32 != 32'd0) && ((line32 & (line32 - 32'd1)) == 32'd0);
        line_mask   = line_ok ? (line32 - 32'd1) : 32'd0;
        offs        = word32 & line_mask;
        aligned     = line_ok && (cur_addr[1:0] == 2'b00) && (offs == 32'd0);
        to_boundary = line_ok ? (line32 - offs) : 32'd0;
    end

endmodule

// File: rtl/pci_wcmd_policy.sv
module pci_wcmd_policy
    import pci_wcmd_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int LVL_W   = 8,
    parameter int CLS_W   = 8,
    parameter int BURST_W = 8
) (
    input  logic [1:0]         xfer_type,
    input  logic               inv_en,
    input  logic [CNT_W-1:0]   remain_bytes,
    input  logic [LVL_W-1:0]   fifo_words,
    input  logic [CLS_W-1:0]   line_words,
    input  logic               line_ok,
    input  logic [31:0]        line_mask,
    input  logic               aligned,
    input  logic [31:0]        to_boundary,
    output logic [3:0]         cmd,
    output logic [BURST_W-1:0] lim,
    output logic               ready
);

    localparam logic [31:0] MAXB = 32'((64'd1 << BURST_W) - 64'd1);

    logic [31:0] fifo32;
    logic [31:0] full32;
    logic [31:0] ceil32;
    logic [31:0] cap;
    logic        eligible;
    logic        promote;

    always_comb begin
        fifo32   = 32'(fifo_words);
        full32   = 32'(remain_bytes) >> 2;
        ceil32   = (32'(remain_bytes) + 32'd3) >> 2;
        eligible = (xfer_type == XT_MEMWRINV) && inv_en && line_ok;
        promote  = eligible && aligned && (full32 >= 32'(line_words));

        if (xfer_type == XT_IOWR)
            cmd = CMD_IOWR;
        else if (promote)
            cmd = CMD_MEMWRINV;
        else
            cmd = CMD_MEMWR;

        if (promote) begin
            // whole lines only, bounded by data present and data left
            cap = min_u32(min_u32(fifo32, full32), MAXB) & ~line_mask;
        end else begin
            cap = min_u32(min_u32(fifo32, ceil32), MAXB);
            // plain write in a promotable stream stops at the line edge
            if (eligible)
                cap = min_u32(cap, to_boundary);
        end

        ready = (remain_bytes != '0) && (cap != 32'd0);
        lim   = cap[BURST_W-1:0];
    end

endmodule

// File: rtl/pci_wcmd_fsm.sv
module pci_wcmd_fsm
    import pci_wcmd_pkg::*;
#(
    parameter int BURST_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               remain_zero,
    input  logic               ready,
    input  logic [3:0]         cmd_in,
    input  logic [BURST_W-1:0] lim_in,
    input  logic               start_ack,
    input  logic               burst_done,
    input  logic               target_disc,
    output logic               start_req,
    output logic [3:0]         cbe_cmd,
    output logic [BURST_W-1:0] burst_lim
);

    sel_state_t state, state_nx;
    logic       take;

    assign take = (state == ST_EVAL) && req_valid && !remain_zero && ready;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (req_valid) state_nx = ST_EVAL;
            ST_EVAL: begin
                if (!req_valid || remain_zero) state_nx = ST_IDLE;
                else if (ready)                state_nx = ST_ISSUE;
            end
            ST_ISSUE: if (start_ack) state_nx = ST_BUSY;
            ST_BUSY:  if (burst_done || target_disc) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cbe_cmd   <= CMD_NONE;
            burst_lim <= '0;
        end else if (take) begin
            cbe_cmd   <= cmd_in;
            burst_lim <= lim_in;
        end
    end

    assign start_req = (state == ST_ISSUE);

    // R9: pending start frozen until acknowledged
    a_r9_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (start_req && !start_ack) |=> (start_req && $stable(cbe_cmd) && $stable(burst_lim)));

    a_r9_leave_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (start_req && start_ack) |=> !start_req);

endmodule

// File: rtl/pci_wcmd_sel.sv
module pci_wcmd_sel
    import pci_wcmd_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int CNT_W   = 16,
    parameter int LVL_W   = 8,
    parameter int CLS_W   = 8,
    parameter int BURST_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [1:0]         xfer_type,
    input  logic               inv_en,
    input  logic [ADDR_W-1:0]  cur_addr,
    input  logic [CNT_W-1:0]   remain_bytes,
    input  logic [CLS_W-1:0]   line_words,
    input  logic [LVL_W-1:0]   fifo_words,
    input  logic               start_ack,
    input  logic               burst_done,
    input  logic               target_disc,
    output logic               start_req,
    output logic [3:0]         cbe_cmd,
    output logic [BURST_W-1:0] burst_lim
);

    logic               line_ok;
    logic [31:0]        line_mask;
    logic               aligned;
    logic [31:0]        to_boundary;
    logic [3:0]         pol_cmd;
    logic [BURST_W-1:0] pol_lim;
    logic               pol_ready;

    pci_wcmd_linegeo #(.ADDR_W(ADDR_W), .CLS_W(CLS_W)) u_geo (
        .cur_addr    (cur_addr),
        .line_words  (line_words),
        .line_ok     (line_ok),
        .line_mask   (line_mask),
        .aligned     (aligned),
        .to_boundary (to_boundary)
    );

    pci_wcmd_policy #(.CNT_W(CNT_W), .LVL_W(LVL_W), .CLS_W(CLS_W), .BURST_W(BURST_W)) u_pol (
        .xfer_type    (xfer_type),
        .inv_en       (inv_en),
        .remain_bytes (remain_bytes),
        .fifo_words   (fifo_words),
        .line_words   (line_words),
        .line_ok      (line_ok),
        .line_mask    (line_mask),
        .aligned      (aligned),
        .to_boundary  (to_boundary),
        .cmd          (pol_cmd),
        .lim          (pol_lim),
        .ready        (pol_ready)
    );

    pci_wcmd_fsm #(.BURST_W(BURST_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .remain_zero (remain_bytes == '0),
        .ready       (pol_ready),
        .cmd_in      (pol_cmd),
        .lim_in      (pol_lim),
        .start_ack   (start_ack),
        .burst_done  (burst_done),
        .target_disc (target_disc),
        .start_req   (start_req),
        .cbe_cmd     (cbe_cmd),
        .burst_lim   (burst_lim)
    );

    // R4: promoted command needs the enable bit at decision time
    a_r4_inv_gate: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(start_req) && cbe_cmd == CMD_MEMWRINV) |-> $past(inv_en));

    // R7: a whole line was in the FIFO when the promoted burst was chosen
    a_r7_line_present: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(start_req) && cbe_cmd == CMD_MEMWRINV) |->
            (32'($past(fifo_words)) >= 32'($past(line_words))));

    // R5: promoted limit is a whole number of lines
    a_r5_whole_lines: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(start_req) && cbe_cmd == CMD_MEMWRINV) |->
            ((32'(burst_lim) & (32'($past(line_words)) - 32'd1)) == 32'd0));

    // R11: limit non-zero and within the FIFO level
    a_r11_lim_legal: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(start_req) |-> (burst_lim != '0) && (32'(burst_lim) <= 32'($past(fifo_words))));

    // R3: I/O request always yields the I/O command
    a_r3_io_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(start_req) && $past(xfer_type) == XT_IOWR) |-> (cbe_cmd == CMD_IOWR));

endmodule

// File: tb/pci_wcmd_sel_test.sv
module pci_wcmd_sel_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  xfer_type = 2'b00;
    logic        inv_en = 1'b0;
    logic [31:0] cur_addr = '0;
    logic [15:0] remain_bytes = '0;
    logic [7:0]  line_words = '0;
    logic [7:0]  fifo_words = '0;
    logic        start_ack = 1'b0;
    logic        burst_done = 1'b0;
    logic        target_disc = 1'b0;
    logic        start_req;
    logic [3:0]  cbe_cmd;
    logic [7:0]  burst_lim;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    localparam logic [3:0] MW  = 4'b0111;
    localparam logic [3:0] MWI = 4'b1111;
    localparam logic [3:0] IOW = 4'b0011;

    pci_wcmd_sel uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .xfer_type(xfer_type),
        .inv_en(inv_en), .cur_addr(cur_addr), .remain_bytes(remain_bytes),
        .line_words(line_words), .fifo_words(fifo_words), .start_ack(start_ack),
        .burst_done(burst_done), .target_disc(target_disc), .start_req(start_req),
        .cbe_cmd(cbe_cmd), .burst_lim(burst_lim)
    );

    always #10 clk = ~clk;

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                n_fail++;
                $display("FAIL watchdog: run hung, actual %0d cycles expected < 100000", cycles);
                $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
                $finish;
            end
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", tag, act, act, exp, exp);
        end
    endtask

    task automatic setup(input logic [1:0] t, input logic ie, input logic [31:0] a,
                         input int rem, input int lw, input int fw);
        @(negedge clk);
        xfer_type    = t;
        inv_en       = ie;
        cur_addr     = a;
        remain_bytes = 16'(rem);
        line_words   = 8'(lw);
        fifo_words   = 8'(fw);
        req_valid    = 1'b1;
    endtask

    // wait for a start, compare it, then ack and close the burst
    task automatic run_burst(input logic [3:0] ecmd, input int elim, input string tag,
                             input bit use_disc);
        int n = 0;
        while (!start_req && n < 30) begin
            @(negedge clk);
            n++;
        end
        check(start_req == 1'b1, {tag, " start_req"}, int'(start_req), 1);
        check(cbe_cmd == ecmd, {tag, " cmd"}, int'(cbe_cmd), int'(ecmd));
        check(int'(burst_lim) == elim, {tag, " limit"}, int'(burst_lim), elim);
        start_ack = 1'b1;
        @(negedge clk);
        start_ack = 1'b0;
        req_valid = 1'b0;
        if (use_disc) target_disc = 1'b1;
        else          burst_done  = 1'b1;
        @(negedge clk);
        target_disc = 1'b0;
        burst_done  = 1'b0;
        @(negedge clk);
    endtask

    task automatic expect_no_start(input int ncyc, input string tag);
        bit seen = 1'b0;
        for (int i = 0; i < ncyc; i++) begin
            @(negedge clk);
            if (start_req) seen = 1'b1;
        end
        check(!seen, tag, int'(seen), 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(start_req == 1'b0, "R1 start_req", int'(start_req), 0);
        check(cbe_cmd == 4'b0000, "R1 cmd", int'(cbe_cmd), 0);
        check(burst_lim == 8'd0, "R1 limit", int'(burst_lim), 0);
    endtask

    task automatic t_memwr();
        setup(2'b00, 1'b0, 32'h100, 64, 8, 10);
        run_burst(MW, 10, "R2 fifo-bound", 1'b0);
        setup(2'b00, 1'b0, 32'h100, 22, 8, 40);
        run_burst(MW, 6, "R2 count-bound ceil", 1'b0);
        setup(2'b00, 1'b1, 32'h100, 2000, 8, 255);
        run_burst(MW, 255, "R2 max-bound", 1'b0);
    endtask

    task automatic t_iowr();
        setup(2'b10, 1'b1, 32'h100, 100, 8, 3);
        run_burst(IOW, 3, "R3 io", 1'b0);
    endtask

    task automatic t_inv_off();
        setup(2'b01, 1'b0, 32'h100, 64, 8, 20);
        run_burst(MW, 16, "R4 inv disabled", 1'b0);
    endtask

    task automatic t_promote();
        setup(2'b01, 1'b1, 32'h100, 100, 8, 20);
        run_burst(MWI, 16, "R5 fifo floor", 1'b0);
        setup(2'b01, 1'b1, 32'h100, 100, 8, 30);
        run_burst(MWI, 24, "R5 count floor", 1'b0);
    endtask

    task automatic t_demote();
        setup(2'b01, 1'b1, 32'h108, 100, 8, 20);
        run_burst(MW, 6, "R6 unaligned to boundary", 1'b0);
        setup(2'b01, 1'b1, 32'h100, 20, 8, 20);
        run_burst(MW, 5, "R6 short tail", 1'b0);
    endtask

    task automatic t_wait_line();
        setup(2'b01, 1'b1, 32'h200, 100, 8, 5);
        expect_no_start(10, "R7 no start below a line");
        fifo_words = 8'd12;
        run_burst(MWI, 8, "R7 start once line present", 1'b0);
    endtask

    task automatic t_line_size();
        setup(2'b01, 1'b1, 32'h100, 100, 0, 20);
        run_burst(MW, 20, "R8 zero line size", 1'b0);
        setup(2'b01, 1'b1, 32'h100, 100, 6, 20);
        run_burst(MW, 20, "R8 non-pow2 line size", 1'b0);
    endtask

    task automatic t_hold();
        int n = 0;
        bit bad = 1'b0;
        setup(2'b00, 1'b0, 32'h100, 400, 8, 9);
        while (!start_req && n < 30) begin
            @(negedge clk);
            n++;
        end
        check(start_req == 1'b1, "R9 start seen", int'(start_req), 1);
        fifo_words = 8'd2;
        xfer_type  = 2'b10;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            if (!start_req || cbe_cmd != MW || burst_lim != 8'd9) bad = 1'b1;
        end
        check(!bad, "R9 held without ack", int'(bad), 0);
        check(cbe_cmd == MW && burst_lim == 8'd9, "R9 values", int'(burst_lim), 9);
        run_burst(MW, 9, "R9 ack", 1'b0);
    endtask

    task automatic t_disconnect();
        setup(2'b01, 1'b1, 32'h100, 64, 8, 16);
        run_burst(MWI, 16, "R10 first line", 1'b1);
        // three words went out before the disconnect
        setup(2'b01, 1'b1, 32'h10C, 52, 8, 13);
        run_burst(MW, 5, "R10 remainder of line", 1'b0);
        setup(2'b01, 1'b1, 32'h120, 32, 8, 8);
        run_burst(MWI, 8, "R10 next line promoted", 1'b0);
    endtask

    task automatic t_empty();
        setup(2'b00, 1'b0, 32'h100, 40, 8, 0);
        expect_no_start(10, "R11 empty fifo");
        remain_bytes = 16'd0;
        fifo_words   = 8'd5;
        expect_no_start(10, "R11 nothing remaining");
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reserved();
        setup(2'b11, 1'b1, 32'h100, 100, 8, 20);
        run_burst(MW, 20, "R12 reserved type", 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_memwr();
        t_iowr();
        t_inv_off();
        t_promote();
        t_demote();
        t_wait_line();
        t_line_size();
        t_hold();
        t_disconnect();
        t_empty();
        t_reserved();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule